// File: doc/BRIEF.md
# SAR ADC Readout Sequencer

This block is the host-side controller for a serial successive-approximation converter. It drives an active-low chip select and a divided serial clock. It shifts in the converter's data line, takes the result field out of each frame and returns it to a user interface. That interface works by request and valid: a request is accepted while the block is not busy, and the matching result later arrives with a one-cycle valid pulse.

The converter gives a bad result on its first conversion after power-up. It does the same on the first conversion after an idle period longer than its maximum throughput time. The sequencer tracks both conditions by itself. After reset it runs one throwaway frame on its own. It also counts the system clocks during which chip select has been high since the last frame. When a request comes in after too long a gap, it runs a throwaway frame first and only then the real one. Data from throwaway frames never reaches the user.

The idle limit is derived from the system clock in MHz and the allowed gap in nanoseconds. The serial clock ratio, the frame length, the result width and its position, and the minimum chip-select high time are all parameters.

Top module: `sar_rdout_seq`

## Requirements
- R1: While reset is asserted, adc_cs_n_o is 1, adc_sclk_o is 0, res_valid_o is 0 and busy_o is 0.
- R2: Each frame holds adc_cs_n_o low for exactly FRAME_BITS*CLK_DIV system clocks. During that time adc_sclk_o makes exactly FRAME_BITS rising edges, each half period lasting CLK_DIV/2 clocks and starting low. adc_sclk_o is 0 whenever adc_cs_n_o is 1.
- R3: Data is sampled as adc_sclk_o rises, and the first bit sampled is frame bit FRAME_BITS-1. res_data_o is frame bits [FRAME_BITS-1-LEAD_BITS : FRAME_BITS-LEAD_BITS-RES_BITS], MSB first. With the defaults that is bits [11:0] of the 16-bit frame, i.e. the 5th to 16th sampled bits.
- R4: After reset the block starts one throwaway frame without any request. No result is ever delivered before two frames have run.
- R5: A frame is a throwaway if adc_cs_n_o was high for more than IDLE_LIMIT = SYS_CLK_MHZ*MAX_GAP_NS/1000 consecutive clocks before it, or if it is the first frame after reset. Otherwise it is a real frame.
- R6: adc_cs_n_o stays high for at least CS_HIGH_MIN clocks between frames.
- R7: A request that is pending when a throwaway frame ends starts its real frame after exactly CS_HIGH_MIN high clocks.
- R8: busy_o rises on the clock edge that accepts a request (req_i high while busy_o is low). It falls in the same cycle as the matching res_valid_o pulse. A request made while busy_o is high is ignored and starts no frame.
- R9: When a request is accepted on edge A, adc_cs_n_o has already been high for at least CS_HIGH_MIN-1 clocks, and no throwaway is needed, res_valid_o is high in the cycle after edge A+FRAME_BITS*CLK_DIV+1.
- R10: res_valid_o is a single-cycle pulse. It is raised together with the rise of adc_cs_n_o at the end of every real frame, and never after a throwaway frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Conversion request, accepted while busy_o is low |
| busy_o | output | 1 | A request is being served |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | RES_BITS | Conversion result |
| adc_cs_n_o | output | 1 | Converter chip select, active low |
| adc_sclk_o | output | 1 | Converter serial clock |
| adc_sdata_i | input | 1 | Converter serial data |

## Verification
A real frame's result is due one clock after chip select has been low for FRAME_BITS*CLK_DIV cycles. A throwaway adds FRAME_BITS*CLK_DIV plus CS_HIGH_MIN cycles in front of that. The bench measures chip-select low and high runs, and the latency from the accepting edge, in whole cycles sampled on falling clock edges. It compares them with values worked out from the parameters. It sweeps the request delay after a result across the idle-limit boundary. For each delay it predicts the latency, the high run in front of the frame and whether a throwaway appears, and it checks the data field against a converter model that sends a different word in every frame.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
   typedef enum logic {
      SEQ_IDLE  = 1'b0,
      SEQ_FRAME = 1'b1
   } seq_state_t;

   function automatic int unsigned gap_cycles(input int unsigned mhz, input int unsigned ns);
      return (mhz * ns) / 1000;
   endfunction
endpackage

// File: rtl/sar_seq_sclk.sv
module sar_seq_sclk #(
   parameter int unsigned CLK_DIV    = 4,
   parameter int unsigned FRAME_BITS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic sclk_o,
   output logic sample_o,
   output logic last_o
);
   localparam int unsigned HALF  = CLK_DIV / 2;
   localparam int unsigned CNT_W = $clog2(CLK_DIV);
   localparam int unsigned BIT_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
   localparam bit          POW2  = ((CLK_DIV & (CLK_DIV - 1)) == 0);

   logic [CNT_W-1:0] cnt_q;
   logic [BIT_W-1:0] bit_q;
   logic             wrap;

   assign wrap     = (cnt_q == CNT_W'(CLK_DIV - 1));
   assign sample_o = run_i && (cnt_q == CNT_W'(HALF - 1));
   assign last_o   = run_i && wrap && (bit_q == BIT_W'(FRAME_BITS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         bit_q <= '0;
      end else if (!run_i) begin
         cnt_q <= '0;
         bit_q <= '0;
      end else if (wrap) begin
         cnt_q <= '0;
         bit_q <= bit_q + 1'b1;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   generate
      if (POW2) begin : g_msb_phase
         // power-of-two ratio: counter MSB is already the high half
         assign sclk_o = cnt_q[CNT_W-1];
      end else begin : g_cmp_phase
         logic sclk_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             sclk_q <= 1'b0;
            else if (!run_i)                        sclk_q <= 1'b0;
            else if (cnt_q == CNT_W'(HALF - 1))     sclk_q <= 1'b1;
            else if (wrap)                          sclk_q <= 1'b0;
         end
         assign sclk_o = sclk_q;
      end
   endgenerate
endmodule

// File: rtl/sar_seq_capture.sv
module sar_seq_capture #(
   parameter int unsigned FRAME_BITS = 16,
   parameter int unsigned RES_BITS   = 12,
   parameter int unsigned LEAD_BITS  = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sample_i,
   input  logic                sdata_i,
   output logic [RES_BITS-1:0] result_o
);
   // leading bits fall off the top, so only the field and any tail are stored
   localparam int unsigned SH_W = FRAME_BITS - LEAD_BITS;

   logic [SH_W-1:0] shift_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        shift_q <= '0;
      else if (sample_i) shift_q <= {shift_q[SH_W-2:0], sdata_i};
   end

   assign result_o = shift_q[SH_W-1 -: RES_BITS];
endmodule

// File: rtl/sar_seq_idle.sv
module sar_seq_idle #(
   parameter int unsigned IDLE_LIMIT  = 4000,
   parameter int unsigned CS_HIGH_MIN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic done_i,
   output logic fresh_o,
   output logic gap_ok_o,
   output logic primed_o
);
   localparam int unsigned CNT_W = $clog2(IDLE_LIMIT + 1);

   logic [CNT_W-1:0] idle_q;
   logic             primed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_q   <= '0;
         primed_q <= 1'b0;
      end else begin
         if (done_i) primed_q <= 1'b1;
         if (run_i)                              idle_q <= '0;
         else if (idle_q != CNT_W'(IDLE_LIMIT))  idle_q <= idle_q + 1'b1;
      end
   end

   assign primed_o = primed_q;
   assign fresh_o  = primed_q && (idle_q < CNT_W'(IDLE_LIMIT));
   assign gap_ok_o = (idle_q >= CNT_W'(CS_HIGH_MIN - 1));
endmodule

// File: rtl/sar_rdout_seq.sv
module sar_rdout_seq
   import sar_seq_pkg::*;
#(
   parameter int unsigned CLK_DIV     = 4,
   parameter int unsigned FRAME_BITS  = 16,
   parameter int unsigned RES_BITS    = 12,
   parameter int unsigned LEAD_BITS   = 4,
   parameter int unsigned SYS_CLK_MHZ = 200,
   parameter int unsigned MAX_GAP_NS  = 20000,
   parameter int unsigned CS_HIGH_MIN = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_i,
   output logic                busy_o,
   output logic                res_valid_o,
   output logic [RES_BITS-1:0] res_data_o,
   output logic                adc_cs_n_o,
   output logic                adc_sclk_o,
   input  logic                adc_sdata_i
);
   localparam int unsigned IDLE_LIMIT = gap_cycles(SYS_CLK_MHZ, MAX_GAP_NS);

   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be even and at least 2");
      end
      if (FRAME_BITS < LEAD_BITS + RES_BITS || RES_BITS < 2) begin : g_bad_field
         $error("result field does not fit in the frame");
      end
      if (CS_HIGH_MIN < 1 || IDLE_LIMIT <= CS_HIGH_MIN) begin : g_bad_gap
         $error("idle limit must exceed the minimum chip-select high time");
      end
   endgenerate

   seq_state_t          state_q;
   logic                dummy_q;
   logic                pend_q;
   logic                valid_q;
   logic [RES_BITS-1:0] data_q;

   logic                run;
   logic                sample;
   logic                last;
   logic                fresh;
   logic                gap_ok;
   logic                primed;
   logic                accept;
   logic [RES_BITS-1:0] result;

   assign run    = (state_q == SEQ_FRAME);
   assign accept = req_i && !pend_q;

   sar_seq_sclk #(.CLK_DIV(CLK_DIV), .FRAME_BITS(FRAME_BITS)) sclk_i (
      .clk(clk), .rst_n(rst_n), .run_i(run),
      .sclk_o(adc_sclk_o), .sample_o(sample), .last_o(last)
   );

   sar_seq_capture #(.FRAME_BITS(FRAME_BITS), .RES_BITS(RES_BITS), .LEAD_BITS(LEAD_BITS)) cap_i (
      .clk(clk), .rst_n(rst_n), .sample_i(sample),
      .sdata_i(adc_sdata_i), .result_o(result)
   );

   sar_seq_idle #(.IDLE_LIMIT(IDLE_LIMIT), .CS_HIGH_MIN(CS_HIGH_MIN)) idle_i (
      .clk(clk), .rst_n(rst_n), .run_i(run), .done_i(last),
      .fresh_o(fresh), .gap_ok_o(gap_ok), .primed_o(primed)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         dummy_q <= 1'b0;
         pend_q  <= 1'b0;
         valid_q <= 1'b0;
         data_q  <= '0;
      end else begin
         valid_q <= 1'b0;
         if (accept) pend_q <= 1'b1;
         case (state_q)
            SEQ_IDLE: begin
               // an unprimed converter launches a frame even without a request
               if (gap_ok && (pend_q || !primed)) begin
                  state_q <= SEQ_FRAME;
                  dummy_q <= !fresh;
               end
            end
            default: begin
               if (last) begin
                  state_q <= SEQ_IDLE;
                  if (!dummy_q) begin
                     valid_q <= 1'b1;
                     data_q  <= result;
                     pend_q  <= 1'b0;
                  end
               end
            end
         endcase
      end
   end

   assign adc_cs_n_o  = !run;
   assign busy_o      = pend_q;
   assign res_valid_o = valid_q;
   assign res_data_o  = data_q;
endmodule

// File: rtl/sar_rdout_seq_chk.sv
module sar_rdout_seq_chk #(
   parameter int unsigned CS_HIGH_MIN = 4
) (
   input logic clk,
   input logic rst_n,
   input logic busy_o,
   input logic res_valid_o,
   input logic adc_cs_n_o,
   input logic adc_sclk_o
);
   logic [7:0] hi_run_q;
   logic [1:0] falls_q;
   logic       cs_d_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run_q <= '0;
         falls_q  <= '0;
         cs_d_q   <= 1'b1;
      end else begin
         cs_d_q <= adc_cs_n_o;
         if (!adc_cs_n_o)             hi_run_q <= '0;
         else if (hi_run_q != 8'hFF)  hi_run_q <= hi_run_q + 1'b1;
         if (cs_d_q && !adc_cs_n_o && falls_q != 2'd2) falls_q <= falls_q + 1'b1;
      end
   end

   assert_sclk_parked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      adc_cs_n_o |-> !adc_sclk_o);

   assert_cs_high_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_d_q && !adc_cs_n_o) |-> (hi_run_q >= 8'(CS_HIGH_MIN)));

   assert_no_early_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o |-> (falls_q == 2'd2));

   assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o |=> !res_valid_o);

   assert_valid_at_frame_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o |-> (adc_cs_n_o && !cs_d_q));

   assert_busy_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> res_valid_o);

   assert_busy_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o |-> (!busy_o && $past(busy_o)));
endmodule

bind sar_rdout_seq sar_rdout_seq_chk #(.CS_HIGH_MIN(CS_HIGH_MIN)) chk_i (
   .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .res_valid_o(res_valid_o),
   .adc_cs_n_o(adc_cs_n_o), .adc_sclk_o(adc_sclk_o)
);

// File: tb/sar_rdout_seq_tb_top.sv
`timescale 1ns/1ps
module sar_rdout_seq_tb_top;
   localparam int CLK_DIV   = 4;
   localparam int FBITS     = 16;
   localparam int RBITS     = 12;
   localparam int LBITS     = 4;
   localparam int MHZ       = 2;
   localparam int GAP_NS    = 20000;
   localparam int CS_MIN    = 3;
   localparam int IDLE_LIM  = MHZ * GAP_NS / 1000;
   localparam int FRAME_CYC = FBITS * CLK_DIV;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0;
   logic sdata = 1'b0;
   logic busy, valid, cs_n, sclk;
   logic [RBITS-1:0] data;

   always #2.5 clk = ~clk;

   sar_rdout_seq #(.CLK_DIV(CLK_DIV), .FRAME_BITS(FBITS), .RES_BITS(RBITS), .LEAD_BITS(LBITS),
                   .SYS_CLK_MHZ(MHZ), .MAX_GAP_NS(GAP_NS), .CS_HIGH_MIN(CS_MIN)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req), .busy_o(busy), .res_valid_o(valid),
      .res_data_o(data), .adc_cs_n_o(cs_n), .adc_sclk_o(sclk), .adc_sdata_i(sdata)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [FBITS-1:0] word_of(input int n);
      logic [LBITS-1:0] ld;
      logic [RBITS-1:0] dv;
      ld = LBITS'(n * 5 + 9);
      dv = RBITS'(n * 397 + 11);
      return {ld, dv};
   endfunction

   // converter model: new word each frame, bits change on falling sclk
   int mdl_n = 0;
   int mdl_pos = -1;
   logic [FBITS-1:0] mdl_w = '0;
   always @(negedge cs_n) begin
      mdl_w = word_of(mdl_n);
      mdl_n++;
      sdata = mdl_w[FBITS-1];
      mdl_pos = FBITS - 2;
   end
   always @(negedge sclk) begin
      if (cs_n === 1'b0 && mdl_pos >= 0) begin
         sdata = mdl_w[mdl_pos];
         mdl_pos--;
      end
   end

   // frame monitor
   int mon_frames = 0;
   int hi_run = 0;
   int lo_len = 0;
   int rises = 0;
   bit cs_p = 1'b1;
   bit sclk_p = 1'b0;
   bit dum_exp [0:255];
   int run_of [0:255];

   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (!cs_n) begin
            if (cs_p) begin
               run_of[mon_frames] = hi_run;
               dum_exp[mon_frames] = (mon_frames == 0) || (hi_run > IDLE_LIM);
               if (mon_frames != 0) chk(hi_run >= CS_MIN, "R6 cs high run", hi_run, CS_MIN);
               mon_frames++;
               lo_len = 0;
               rises = 0;
            end
            lo_len++;
            if (sclk && !sclk_p) rises++;
         end else begin
            if (!cs_p) begin
               chk(lo_len == FRAME_CYC, "R2 cs low length", lo_len, FRAME_CYC);
               chk(rises == FBITS, "R2 sclk rising edges", rises, FBITS);
               if (dum_exp[mon_frames-1]) begin
                  chk(!valid, "R10 R4 R5 no result after throwaway", valid, 0);
               end else begin
                  logic [FBITS-1:0] w;
                  w = word_of(mon_frames - 1);
                  chk(valid, "R10 result at real frame end", valid, 1);
                  chk(data == w[RBITS-1:0], "R3 result field", data, w[RBITS-1:0]);
               end
               hi_run = 0;
            end else begin
               chk(!valid, "R10 no result outside frame end", valid, 0);
            end
            chk(!sclk, "R2 sclk parked low", sclk, 0);
            hi_run++;
         end
         cs_p = cs_n;
         sclk_p = sclk;
      end
   end

   task automatic wait_valid(output int cyc);
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
         if (!valid) chk(busy, "R8 busy held until result", busy, 1);
      end while (!valid && cyc < 5000);
      chk(!busy, "R8 busy low with result", busy, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int cyc;
      int f0;
      int jlist [8] = '{1, 2, 5, 38, 39, 40, 41, 60};
      repeat (4) @(negedge clk);
      chk(cs_n == 1'b1, "R1 cs high in reset", cs_n, 1);
      chk(sclk == 1'b0, "R1 sclk low in reset", sclk, 0);
      chk(valid == 1'b0, "R1 valid low in reset", valid, 0);
      chk(busy == 1'b0, "R1 busy low in reset", busy, 0);
      rst_n = 1'b1;

      // R4/R7: autonomous throwaway, request arrives during it
      cyc = 0;
      while (cs_n && cyc < 100) begin @(negedge clk); cyc++; end
      chk(!cs_n, "R4 throwaway frame starts without request", cs_n, 0);
      repeat (5) @(negedge clk);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      chk(busy, "R8 busy after accept", busy, 1);
      repeat (20) @(negedge clk);
      req = 1'b1;                       // ignored: block is busy
      @(negedge clk);
      req = 1'b0;
      wait_valid(cyc);
      chk(mon_frames == 2, "R4 one throwaway before first result", mon_frames, 2);
      chk(run_of[1] == CS_MIN, "R7 held request follows throwaway", run_of[1], CS_MIN);

      // R8: extra request made no frame; long idle follows
      repeat (200) @(negedge clk);
      chk(mon_frames == 2, "R8 request while busy ignored", mon_frames, 2);
      f0 = mon_frames;
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      wait_valid(cyc);
      chk(mon_frames - f0 == 2, "R5 long gap inserts throwaway", mon_frames - f0, 2);
      chk(run_of[f0+1] == CS_MIN, "R7 real frame after gap throwaway", run_of[f0+1], CS_MIN);

      // R5/R9 sweep of request delay across the idle limit
      foreach (jlist[k]) begin
         int j;
         int run_exp;
         bit dum;
         int lat_exp;
         j = jlist[k];
         run_exp = ((j > CS_MIN - 1) ? j : CS_MIN - 1) + 1;
         dum = (run_exp > IDLE_LIM);
         lat_exp = (run_exp - 1 - j) + FRAME_CYC + 1 + (dum ? FRAME_CYC + CS_MIN : 0);
         if (j > 1) repeat (j - 1) @(negedge clk);
         f0 = mon_frames;
         req = 1'b1;
         @(negedge clk);
         req = 1'b0;
         wait_valid(cyc);
         chk(mon_frames - f0 == (dum ? 2 : 1), "R5 throwaway only past idle limit",
             mon_frames - f0, dum ? 2 : 1);
         chk(run_of[f0] == run_exp, "R6 R9 high run before frame", run_of[f0], run_exp);
         chk(cyc == lat_exp, "R9 result latency", cyc, lat_exp);
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule